// File: doc/BRIEF.md
# Fermat Modular Inversion Controller

This block inverts a field element modulo an odd prime p by raising it to the power p − 2. It does no arithmetic of its own beyond forming that exponent. All squarings and products go to an external Montgomery multiplier through a one-cycle request and a one-cycle completion pulse. The controller is intended to run once per scalar multiplication, on the projective Z coordinate. The inverse it returns is then used by other logic to scale X and Y down to affine form.

The operand, the modulus and the Montgomery image of one (R mod p, where R = 2^W) are sampled when a start is accepted. The exponent p − 2 is formed at that moment by a word-serial borrow chain and is scanned from its top bit downward. Each bit always costs one squaring, and a set bit adds a multiply by the operand. Because the exponent is public, the fixed pattern reveals nothing secret. The result stays in Montgomery form and is held until the next accepted start.

Top module: `modinv_fermat`

## Requirements
- R1: After reset, done_o and mul_start_o are low and result_o is zero.
- R2: For operand_i = m·R mod p, with R = 2^W and mont_one_i = R mod p, result_o at done equals (m^(p−2) mod p)·R mod p.
- R3: A zero operand yields a zero result, and done_o still pulses.
- R4: The exponent p − 2 is correct when the subtraction borrows across a word boundary (for example p = 257, exponent 0x00FF).
- R5: A run issues exactly W + popcount(p − 2) multiplier requests, scanning from the most significant of the W exponent bits. The first request is a squaring of the Montgomery one: both operands equal mont_one_i.
- R6: mul_start_o is a single-cycle pulse. mul_a_o and mul_b_o hold steady in the cycle after a request.
- R7: Each mul_done_i is followed in the next cycle by either a new request or done_o. done_o is a single-cycle pulse that never coincides with a request. For a multiplier latency of L cycles, the first cycle that done_o is high falls n·(L+2)+1 cycles after the start edge, where n is the number of requests.
- R8: A start_i pulse during a run is ignored. The result and the request count match a run without that pulse.
- R9: result_o changes only on an accepted start or a multiplier completion, so it holds after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an inversion; accepted only when idle |
| operand_i | input | W | Element to invert, in Montgomery form |
| modulus_i | input | W | Odd prime modulus p |
| mont_one_i | input | W | R mod p, the Montgomery one |
| mul_start_o | output | 1 | One-cycle request to the multiplier |
| mul_a_o | output | W | First multiplier operand (accumulator) |
| mul_b_o | output | W | Second multiplier operand (accumulator or operand) |
| mul_done_i | input | 1 | One-cycle completion from the multiplier |
| mul_res_i | input | W | Multiplier result, valid with mul_done_i |
| done_o | output | 1 | One-cycle pulse when result_o is final |
| result_o | output | W | Inverse in Montgomery form |

## Verification
The next step after each multiplier completion is due one cycle later: either a request or done_o. With the bench multiplier answering L = 3 cycles after a request, every request–completion round costs L+2 cycles. The first cycle that done_o is high therefore lands n·(L+2)+1 cycles after the accepting edge. The bench counts cycles on falling edges from that edge and compares the count at done_o with this figure. It reads result_o and tallies requests on the same falling edges, away from the clock edge that updates them. It checks that result_o is still unchanged several cycles after done_o.

// File: rtl/modinv_pkg.sv
`timescale 1ns/1ps
package modinv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SQ_GO   = 3'd1,
    ST_SQ_WAIT = 3'd2,
    ST_ML_GO   = 3'd3,
    ST_ML_WAIT = 3'd4,
    ST_FIN     = 3'd5
  } inv_state_t;
endpackage

// File: rtl/modinv_rst_sync.sv
`timescale 1ns/1ps
module modinv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/modinv_exp_sub.sv
`timescale 1ns/1ps
// Forms p - 2 one word at a time, rippling the borrow upward.
module modinv_exp_sub #(
  parameter int W      = 16,
  parameter int WORD_W = 8
) (
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] exp_o
);
  localparam int NWORDS = W / WORD_W;

  logic [NWORDS-1:0] borrow_in;
  assign borrow_in[0] = 1'b0;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [WORD_W-1:0] SUBV = (i == 0) ? WORD_W'(2) : '0;
    logic [WORD_W-1:0] a_w;
    assign a_w = mod_i[i*WORD_W +: WORD_W];
    if (i < NWORDS - 1) begin : g_mid
      logic [WORD_W:0] t;
      assign t = {1'b0, a_w} - {1'b0, SUBV} - {{WORD_W{1'b0}}, borrow_in[i]};
      assign exp_o[i*WORD_W +: WORD_W] = t[WORD_W-1:0];
      assign borrow_in[i+1] = t[WORD_W];
    end else begin : g_top
      assign exp_o[i*WORD_W +: WORD_W] = a_w - SUBV - {{(WORD_W-1){1'b0}}, borrow_in[i]};
    end
  end
endmodule

// File: rtl/modinv_exp_sched.sv
`timescale 1ns/1ps
// Holds the exponent and walks it from the top bit down.
module modinv_exp_sched #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] exp_i,
  output logic         bit_o,
  output logic         last_o
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     exp_q, exp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    en    = load_i | adv_i;
    exp_d = exp_q;
    cnt_d = cnt_q;
    if (load_i) begin
      exp_d = exp_i;
      cnt_d = CNT_W'(W - 1);
    end else if (adv_i) begin
      exp_d = {exp_q[W-2:0], 1'b0};
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      exp_q <= exp_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o  = exp_q[W-1];
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/modinv_fermat.sv
`timescale 1ns/1ps
module modinv_fermat
  import modinv_pkg::*;
#(
  parameter int W      = 16,
  parameter int WORD_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] modulus_i,
  input  logic [W-1:0] mont_one_i,
  output logic         mul_start_o,
  output logic [W-1:0] mul_a_o,
  output logic [W-1:0] mul_b_o,
  input  logic         mul_done_i,
  input  logic [W-1:0] mul_res_i,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic rst_s_n;
  inv_state_t state_q, state_d;
  logic [W-1:0] acc_q, acc_d, opnd_q, opnd_d, exp_val;
  logic acc_en, opnd_en, exp_load, exp_adv, cur_bit, last_bit;

  modinv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  modinv_exp_sub #(.W(W), .WORD_W(WORD_W)) u_sub (
    .mod_i (modulus_i),
    .exp_o (exp_val)
  );

  modinv_exp_sched #(.W(W)) u_sched (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (exp_load),
    .adv_i  (exp_adv),
    .exp_i  (exp_val),
    .bit_o  (cur_bit),
    .last_o (last_bit)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    acc_d       = acc_q;
    opnd_d      = opnd_q;
    acc_en      = 1'b0;
    opnd_en     = 1'b0;
    exp_load    = 1'b0;
    exp_adv     = 1'b0;
    mul_start_o = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          acc_d    = mont_one_i;
          acc_en   = 1'b1;
          opnd_d   = operand_i;
          opnd_en  = 1'b1;
          exp_load = 1'b1;
          state_d  = ST_SQ_GO;
        end
      end
      ST_SQ_GO: begin
        mul_start_o = 1'b1;
        state_d     = ST_SQ_WAIT;
      end
      ST_SQ_WAIT: begin
        if (mul_done_i) begin
          acc_d  = mul_res_i;
          acc_en = 1'b1;
          if (cur_bit)       state_d = ST_ML_GO;
          else if (last_bit) state_d = ST_FIN;
          else begin
            exp_adv = 1'b1;
            state_d = ST_SQ_GO;
          end
        end
      end
      ST_ML_GO: begin
        mul_start_o = 1'b1;
        state_d     = ST_ML_WAIT;
      end
      ST_ML_WAIT: begin
        if (mul_done_i) begin
          acc_d  = mul_res_i;
          acc_en = 1'b1;
          if (last_bit) state_d = ST_FIN;
          else begin
            exp_adv = 1'b1;
            state_d = ST_SQ_GO;
          end
        end
      end
      ST_FIN: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      opnd_q  <= '0;
    end else begin
      state_q <= state_d;
      if (acc_en)  acc_q  <= acc_d;
      if (opnd_en) opnd_q <= opnd_d;
    end
  end

  assign mul_a_o  = acc_q;
  assign mul_b_o  = (state_q == ST_ML_GO || state_q == ST_ML_WAIT) ? opnd_q : acc_q;
  assign result_o = acc_q;
endmodule

// File: rtl/modinv_fermat_chk.sv
`timescale 1ns/1ps
module modinv_fermat_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         mul_start_o,
  input logic [W-1:0] mul_a_o,
  input logic [W-1:0] mul_b_o,
  input logic         mul_done_i,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start_o |=> !mul_start_o);

  // R6
  opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start_o |=> ($stable(mul_a_o) && $stable(mul_b_o)));

  // R7
  next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done_i |=> (mul_start_o || done_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mul_start_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mul_done_i && !start_i) |=> $stable(result_o));
endmodule

bind modinv_fermat modinv_fermat_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mul_start_o (mul_start_o),
  .mul_a_o     (mul_a_o),
  .mul_b_o     (mul_b_o),
  .mul_done_i  (mul_done_i),
  .done_o      (done_o),
  .result_o    (result_o)
);

// File: tb/tb_modinv_fermat.sv
`timescale 1ns/1ps
module tb_modinv_fermat;
  localparam int W       = 16;
  localparam int MUL_LAT = 3;
  localparam int NV      = 8;
  // {p, m} pairs, m in plain form
  localparam logic [31:0] VECS [NV] = '{
    32'hFFF1_0002, 32'hFFF1_FFF0, 32'hFFF1_3039, 32'h00FB_0001,
    32'h00FB_00FA, 32'h0101_0064, 32'h0007_0003, 32'h0003_0002
  };

  logic clk, rst_n, start_i, mul_start_o, mul_done_i, done_o;
  logic [W-1:0] operand_i, modulus_i, mont_one_i, mul_a_o, mul_b_o, mul_res_i, result_o;
  int checks, failures;
  longint unsigned cur_p;
  int mcnt;
  logic [W-1:0] a_l, b_l;

  modinv_fermat #(.W(W), .WORD_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .modulus_i(modulus_i), .mont_one_i(mont_one_i), .mul_start_o(mul_start_o),
    .mul_a_o(mul_a_o), .mul_b_o(mul_b_o), .mul_done_i(mul_done_i),
    .mul_res_i(mul_res_i), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint unsigned mont(longint unsigned a, longint unsigned b,
                                           longint unsigned p);
    longint unsigned t = a * b;
    for (int i = 0; i < W; i++) begin
      if (t[0]) t = t + p;
      t = t >> 1;
    end
    if (t >= p) t = t - p;
    return t;
  endfunction

  function automatic longint unsigned modexp(longint unsigned m, longint unsigned e,
                                             longint unsigned p);
    longint unsigned r = 1, b = m % p;
    while (e != 0) begin
      if (e[0]) r = (r * b) % p;
      b = (b * b) % p;
      e = e >> 1;
    end
    return r;
  endfunction

  // Montgomery multiplier model, latency MUL_LAT
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= 0; mul_done_i <= 1'b0; mul_res_i <= '0; a_l <= '0; b_l <= '0;
    end else begin
      mul_done_i <= 1'b0;
      if (mul_start_o) begin
        mcnt <= MUL_LAT; a_l <= mul_a_o; b_l <= mul_b_o;
      end else if (mcnt == 1) begin
        mcnt <= 0; mul_done_i <= 1'b1;
        mul_res_i <= W'(mont(longint'(a_l), longint'(b_l), cur_p));
      end else if (mcnt > 1) mcnt <= mcnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input longint unsigned p, input longint unsigned m,
                          input bit inject, input string req);
    longint unsigned rr = (longint'(1) << W) % p;
    longint unsigned expv = (m == 0) ? 0 : (modexp(m, p - 2, p) * rr) % p;
    int nops = W + $countones(p - 2);
    int cyc = 0, nreq = 0;
    bit seen = 0, got = 0;
    logic [W-1:0] fa = '0, fb = '0, held;
    cur_p = p;
    @(negedge clk);
    modulus_i = W'(p); mont_one_i = W'(rr); operand_i = W'((m * rr) % p);
    start_i = 1'b1;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (inject && cyc == 20) begin start_i = 1'b1; operand_i = W'(7); end
      if (inject && cyc == 21) operand_i = W'((m * rr) % p);
      if (mul_start_o) begin
        nreq++;
        if (!seen) begin seen = 1; fa = mul_a_o; fb = mul_b_o; end
      end
      if (done_o) begin got = 1; break; end
    end
    check(got, req, "done seen (R7 watchdog)", longint'(got), 1);
    check(result_o == W'(expv), req, "result (R2)", longint'(result_o), expv);
    check(nreq == nops, req, "request count (R5)", longint'(nreq), longint'(nops));
    check(fa == W'(rr) && fb == W'(rr), req, "first request squares one (R5)",
          longint'(fb), rr);
    check(cyc == nops * (MUL_LAT + 2) + 1, req, "done latency (R7)",
          longint'(cyc), longint'(nops * (MUL_LAT + 2) + 1));
    held = result_o;
    repeat (5) @(negedge clk);
    check(result_o == held && !done_o, req, "result held after done (R9)",
          longint'(result_o), longint'(held));
  endtask

  initial begin
    #1_600_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; cur_p = 3;
    rst_n = 1'b0; start_i = 1'b0; operand_i = '0; modulus_i = '0; mont_one_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(!done_o && !mul_start_o && result_o == '0, "R1", "reset outputs",
          longint'(result_o), 0);
    // R2, R5, R7, R9 across the table; p=257 exercises the borrow (R4)
    for (int i = 0; i < NV; i++)
      run_case(longint'(VECS[i][31:16]), longint'(VECS[i][15:0]), 1'b0,
               (VECS[i][31:16] == 16'h0101) ? "R4" : "R2");
    // R3 zero operand
    run_case(64'd65521, 64'd0, 1'b0, "R3");
    run_case(64'd257, 64'd0, 1'b0, "R3");
    // R8 start during run ignored
    run_case(64'd65521, 64'd12345, 1'b1, "R8");
    // R6 no request while idle
    repeat (3) @(negedge clk);
    check(!mul_start_o, "R6", "idle request", longint'(mul_start_o), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule